// File: doc/BRIEF.md
# Serial Flash Whole-Device Erase Sequencer

This block sits on the host side of a four-wire SPI link and erases an entire serial flash device with no software involvement. A single-cycle start request makes it send a write-enable command in its own chip-select frame, then the chip-erase opcode in a second frame. It raises chip select straight after the eighth opcode bit, because the flash only begins erasing on that rising edge.

It then opens one status-read frame. It sends the status opcode once and keeps clocking, sampling the status byte that the flash repeats for as long as SCK toggles. When the busy flag reads clear, the frame is closed and a one-cycle done pulse follows. If a parameterised number of status bytes pass while busy is still set, the frame is closed and a one-cycle error pulse is raised instead.

The SCK half period, the erase opcode and the poll limit are parameters. All transfers use SPI mode 0: SCK idles low, MOSI changes on the falling edge, MISO is sampled on the rising edge, and the MSB goes first.

Top module: `flash_erase_seq`

## Requirements
- R1: During and after reset with no start, chip select is high, SCK is low, MOSI is low, and done and error are low.
- R2: A start seen in idle pulls chip select low in the next cycle and sends opcode 06h over 8 bits, MSB first. Each SCK half period lasts CLK_DIV clocks, the low half comes first, and MOSI changes only where SCK falls.
- R3: Between frames, and for the tail after the last frame, chip select stays high for exactly four SCK half periods with SCK and MOSI low.
- R4: The second frame carries only the erase opcode (ERASE_OP, default 60h, 8'hC7 allowed). Chip select rises on the same clock that ends the high half of its eighth bit.
- R5: The third frame sends opcode 05h once, then keeps clocking further 8-bit status bytes in the same frame, with MOSI held low.
- R6: MISO is sampled at each SCK rising edge, and bit 0 (the last bit of each status byte) is the busy flag. The frame ends after the first status byte whose bit 0 is 0.
- R7: If MAX_POLLS status bytes in a row all show busy, the frame ends after the last of them and the run ends with error rather than done.
- R8: Exactly one of done or error is asserted, for one cycle, in the cycle after the four-half-period tail.
- R9: A start that arrives while a run is in progress has no effect on the pins or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to erase the whole device |
| done_o | output | 1 | One-cycle pulse: erase finished |
| error_o | output | 1 | One-cycle pulse: busy never cleared within the poll limit |
| spi_sck_o | output | 1 | Serial clock, idles low |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
Every pin is due at a fixed cycle measured from the edge that accepts start. The first frame appears one cycle later, and every SCK half period lasts exactly CLK_DIV clocks. A gap is four half periods long, and a status frame lasts sixteen half periods per byte, counting the opcode byte. The done or error pulse falls in the single cycle after the tail. The bench lays out a per-clock expected value for chip select, SCK, MOSI, done and error from these counts. It uses the number of busy bytes its flash model will report, and compares every clock at the falling edge, halfway between register updates. Runs cover busy clearing at once, clearing on the last allowed byte, one byte over the limit, and a start pulse injected mid-run.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WREN, ST_GAP_A, ST_ERASE, ST_GAP_B, ST_RDSR, ST_POLL, ST_TAIL
  } fes_state_e;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam int         GAP_HALVES = 4;
endpackage

// File: rtl/fes_tick.sv
module fes_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fes_shift.sv
module fes_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         act_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         miso_i,
  output logic         sck_o,
  output logic         mosi_o,
  output logic [W-1:0] rx_o,
  output logic         last_o
);
  localparam int BW = $clog2(W);
  logic [W-1:0]  tx_q, rx_q;
  logic [BW-1:0] bit_q;
  logic          sck_q;

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[W-1] & act_i;
  assign rx_o   = rx_q;
  // byte ends on the tick closing the high half of its last bit
  assign last_o = act_i & tick_i & sck_q & (bit_q == BW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
      sck_q <= 1'b0;
    end else if (load_i) begin
      tx_q  <= load_data_i;
      bit_q <= '0;
      sck_q <= 1'b0;
    end else if (!act_i) begin
      sck_q <= 1'b0;
    end else if (tick_i) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_q  <= {rx_q[W-2:0], miso_i};
      end else begin
        sck_q <= 1'b0;
        tx_q  <= {tx_q[W-2:0], 1'b0};
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int         CLK_DIV   = 4,
  parameter logic [7:0] ERASE_OP  = 8'h60,
  parameter int         MAX_POLLS = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o,
  output logic error_o,
  output logic spi_sck_o,
  output logic spi_cs_no,
  output logic spi_mosi_o,
  input  logic spi_miso_i
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int GW = $clog2(GAP_HALVES);

  fes_state_e    st_q;
  logic          cs_n_q, ok_q, done_q, err_q;
  logic [PW-1:0] poll_q;
  logic [GW-1:0] gap_q;
  logic          tick, last, load, gap_end, poll_end;
  logic [7:0]    load_byte, rx;

  fes_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i, .rst_ni, .clr_i(st_q == ST_IDLE), .tick_o(tick)
  );

  fes_shift #(.W(8)) u_shift (
    .clk_i, .rst_ni, .tick_i(tick), .act_i(!cs_n_q), .load_i(load),
    .load_data_i(load_byte), .miso_i(spi_miso_i), .sck_o(spi_sck_o),
    .mosi_o(spi_mosi_o), .rx_o(rx), .last_o(last)
  );

  assign gap_end  = tick && (gap_q == GW'(GAP_HALVES - 1));
  assign poll_end = (poll_q == PW'(MAX_POLLS - 1));

  always_comb begin
    load      = 1'b0;
    load_byte = OP_WREN;
    unique case (st_q)
      ST_IDLE:  load = start_i;
      ST_GAP_A: begin load = gap_end; load_byte = ERASE_OP; end
      ST_GAP_B: begin load = gap_end; load_byte = OP_RDSR;  end
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cs_n_q <= 1'b1;
      ok_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      poll_q <= '0;
      gap_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (tick) gap_q <= gap_q + 1'b1;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_WREN;
          cs_n_q <= 1'b0;
        end
        ST_WREN: if (last) begin
          st_q   <= ST_GAP_A;
          cs_n_q <= 1'b1;
          gap_q  <= '0;
        end
        ST_GAP_A: if (gap_end) begin
          st_q   <= ST_ERASE;
          cs_n_q <= 1'b0;
        end
        ST_ERASE: if (last) begin
          st_q   <= ST_GAP_B;   // erase begins in the flash on this rising edge
          cs_n_q <= 1'b1;
          gap_q  <= '0;
        end
        ST_GAP_B: if (gap_end) begin
          st_q   <= ST_RDSR;
          cs_n_q <= 1'b0;
        end
        ST_RDSR: if (last) begin
          st_q   <= ST_POLL;
          poll_q <= '0;
        end
        ST_POLL: if (last) begin
          if (!rx[0] || poll_end) begin
            st_q   <= ST_TAIL;
            cs_n_q <= 1'b1;
            ok_q   <= !rx[0];
            gap_q  <= '0;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        ST_TAIL: if (gap_end) begin
          st_q   <= ST_IDLE;
          done_q <= ok_q;
          err_q  <= !ok_q;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_no = cs_n_q;
  assign done_o    = done_q;
  assign error_o   = err_q;
endmodule

// File: rtl/fes_checker.sv
module fes_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic done_o,
  input logic error_o,
  input logic sck_i,
  input logic cs_ni,
  input logic mosi_i
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !sck_i); // R3

  AST_CS_RISE_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |-> $past(sck_i)); // R4

  AST_MOSI_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && $past(!cs_ni) && !$fell(sck_i)) |-> $stable(mosi_i)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || error_o) |=> !(done_o || error_o)); // R8

  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o)); // R8

  AST_RESULT_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || error_o) |-> ($past(cs_ni) && cs_ni)); // R8
endmodule

bind flash_erase_seq fes_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done_o  (done_o),
  .error_o (error_o),
  .sck_i   (spi_sck_o),
  .cs_ni   (spi_cs_no),
  .mosi_i  (spi_mosi_o)
);

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb;
  localparam int DIV  = 2;
  localparam int MAXP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, err, sck, cs_n, mosi;
  logic miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int shown  = 0;

  always #2 clk = ~clk;

  flash_erase_seq #(.CLK_DIV(DIV), .ERASE_OP(8'h60), .MAX_POLLS(MAXP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done), .error_o(err),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  // behavioural flash: status = {6'b0, write_enable, busy}
  int         bitc = 0;
  logic [7:0] op = 8'h00;
  logic [7:0] stat_sh = 8'h00;
  bit         wel = 1'b0;
  int         busy_left = 0;
  int         busy_cfg = 0;

  always @(negedge cs_n) begin
    bitc = 0;
    op   = 8'h00;
  end

  always @(posedge sck) if (!cs_n) begin
    if (bitc < 8) op = {op[6:0], mosi};
    bitc = bitc + 1;
  end

  always @(negedge sck) if (!cs_n && bitc >= 8 && op == 8'h05) begin
    if (bitc % 8 == 0) begin
      if (bitc > 8 && busy_left > 0) busy_left = busy_left - 1;
      stat_sh = {6'b0, wel, (busy_left != 0)};
    end
    miso = stat_sh[7 - (bitc % 8)];
  end

  always @(posedge cs_n) begin
    if (bitc == 8 && op == 8'h06) wel = 1'b1;
    if (bitc == 8 && op == 8'h60 && wel) begin
      busy_left = busy_cfg;
      wel = 1'b0;
    end
  end

  // expected pins per clock: {cs_n, sck, mosi, done, error}
  logic [4:0] exp_q[$];
  string      tag_q[$];

  task automatic push_half(input logic c, input logic s, input logic m, input string t);
    for (int i = 0; i < DIV; i++) begin
      exp_q.push_back({c, s, m, 1'b0, 1'b0});
      tag_q.push_back(t);
    end
  endtask

  task automatic push_byte(input logic [7:0] b, input string t);
    for (int i = 7; i >= 0; i--) begin
      push_half(1'b0, 1'b0, b[i], t);
      push_half(1'b0, 1'b1, b[i], t);
    end
  endtask

  task automatic push_gap(input string t);
    for (int i = 0; i < 4; i++) push_half(1'b1, 1'b0, 1'b0, t);
  endtask

  task automatic compare(input logic [4:0] exp, input string t);
    logic [4:0] act;
    act = {cs_n, sck, mosi, done, err};
    checks++;
    if (act !== exp) begin
      errors++;
      if (shown < 20) begin
        shown++;
        $display("FAIL %s cs,sck,mosi,done,err actual=%b expected=%b at %0t", t, act, exp, $time);
      end
    end
  endtask

  task automatic run_case(input int k, input bit inject);
    int  polls;
    bit  timeout;
    int  idx;
    timeout = (k + 1 > MAXP);
    polls   = timeout ? MAXP : k + 1;
    busy_cfg = k;
    push_byte(8'h06, "R2");
    push_gap("R3");
    push_byte(8'h60, "R4");
    push_gap("R3");
    push_byte(8'h05, "R5");
    for (int p = 0; p < polls; p++) push_byte(8'h00, timeout ? "R7" : "R6");
    push_gap("R3");
    exp_q.push_back({1'b1, 1'b0, 1'b0, !timeout, timeout});
    tag_q.push_back("R8");
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    idx = 0;
    while (exp_q.size() > 0) begin
      compare(exp_q.pop_front(), inject ? {"R9/", tag_q.pop_front()} : tag_q.pop_front());
      idx++;
      if (inject && (idx == 45 || idx == 130)) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 6; i++) begin
      compare(5'b10000, inject ? "R9" : "R8");
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(5'b10000, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare(5'b10000, "R1");
    run_case(0, 1'b0);        // R6 busy clear on first status byte
    run_case(2, 1'b1);        // R9 start pulses mid-run
    run_case(MAXP - 1, 1'b0); // R6 clears on last allowed byte
    run_case(MAXP, 1'b0);     // R7 one byte over the limit
    run_case(MAXP + 3, 1'b0); // R7 long busy
    run_case(1, 1'b0);        // R8 recovery after error
    finish_run();
  end
endmodule